// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block turns register writes into software-generated interrupts for a cluster of up to eight processors. A processor writes a trigger word that names one of sixteen software interrupt numbers and a way to choose recipients: an explicit CPU list, every online CPU except the writer, or only the writer. For each recipient the block records which processor raised the interrupt. Each (recipient, interrupt number) pair therefore holds one bit per possible sender. The pair counts as pending whenever any of its sender bits is set.

Two byte-addressable windows give direct access to these sender masks. One window ORs bits in. The other clears them. Both read back the same masks. Every window access goes to the bank that belongs to the processor making the access. The block shows one pending flag per recipient and interrupt number to the logic downstream. Prioritisation, acknowledgement and delivery are outside this block.

The address map is fixed by the decode. The trigger register is at offset 0x00. The clear window is at 0x10–0x1F and the set window is at 0x20–0x2F. In both windows the low four address bits select the interrupt number.

Top module: `sgi_dispatch`

## Requirements
- R1: After a synchronous reset every sender mask is zero, so every bit of `sgi_pend` is 0 and `rd_data` is 0.
- R2: A word write to offset 0x00 is a trigger. In the trigger word, bits [3:0] are the interrupt number, bits [23:16] are the CPU list and bits [25:24] are the filter mode. In mode 0, each CPU in the list that is also online gets sender bit `req_cpu` set for that interrupt. Its pending flag `sgi_pend[cpu*16+id]` is 1 from the cycle after the write.
- R3: In mode 1 the recipients are every CPU whose number is below `online_cpus`, except `req_cpu`. The CPU list is ignored in this mode.
- R4: In mode 2 the only recipient is `req_cpu`. The pending flags of all other CPUs do not change.
- R5: A trigger with mode 3 changes no sender mask and no pending flag.
- R6: In modes 0 and 1, a CPU whose number is greater than or equal to `online_cpus` is never a recipient.
- R7: A write to the set window ORs byte data into the sender masks of the accessing CPU's bank. A zero byte leaves the mask, and therefore the pending flag, unchanged.
- R8: A write to the clear window clears the sender bits that are 1 in each byte. The pending flag stays 1 while any sender bit remains set, and falls to 0 once the mask is empty.
- R9: A window access with `req_word`=1 covers interrupt numbers {addr[3:2],2'b00} to {addr[3:2],2'b11}. Interrupt number {addr[3:2],k} uses byte lane k (bits [8k+7:8k]). A byte access (`req_word`=0) covers interrupt number addr[3:0] through lane addr[1:0]. On a byte read the other lanes return 0.
- R10: A read of the trigger register returns 0. A read of an unmapped offset also returns 0.
- R11: A window access touches only the bank of CPU `req_cpu`. The other banks stay unchanged.
- R12: Read data appears on `rd_data` one cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Register access strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| req_addr | input | 6 | Byte offset of the access |
| req_wdata | input | 32 | Write data (a byte write uses lane addr[1:0]) |
| req_cpu | input | 3 | Number of the CPU making the access |
| online_cpus | input | 4 | Count of online CPUs (0 to 8) |
| rd_data | output | 32 | Registered read data |
| sgi_pend | output | 128 | Pending flag of CPU c, interrupt s, at bit c*16+s |

## Verification
Every result of this block is due exactly one clock edge after its request. This holds for pending flags after a trigger or window write, and for `rd_data` after a read. The bench drives each request on a falling edge and drops it on the next falling edge, so the request covers exactly one rising edge. It compares outputs right there, half a cycle after the edge that registered them and before the next request. The bench sweeps every source CPU and every filter mode over two online counts. It keeps its own sender-mask model, so pending vectors and read-back words are compared bit for bit after each access.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    // Recipient selection carried in bits [25:24] of the trigger word.
    typedef enum logic [1:0] {
        FILT_LIST   = 2'd0,
        FILT_OTHERS = 2'd1,
        FILT_SELF   = 2'd2,
        FILT_RSVD   = 2'd3
    } filt_e;

    // Address regions decoded from the upper offset bits.
    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_TRIG = 2'd1,
        REG_CLR  = 2'd2,
        REG_SET  = 2'd3
    } region_e;

endpackage

// File: rtl/sgi_addr_decode.sv
module sgi_addr_decode
    import sgi_pkg::*;
#(
    parameter int NSGI = 16,
    parameter int AW   = 6
) (
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_word,
    input  logic [AW-1:0]        req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 trig_wr,
    output logic                 set_wr,
    output logic                 clr_wr,
    output logic                 rd_fire,
    output logic                 rd_win,
    output logic [NSGI-1:0]      sel,
    output logic [NSGI*8-1:0]    bytes
);
    localparam int SW = $clog2(NSGI);
    localparam int RW = AW - SW;

    region_e    region;
    logic [7:0] lane_byte;

    always_comb begin
        region = REG_NONE;
        if (req_addr == '0)
            region = REG_TRIG;
        else if (req_addr[AW-1:SW] == RW'(1))
            region = REG_CLR;
        else if (req_addr[AW-1:SW] == RW'(2))
            region = REG_SET;
    end

    assign trig_wr = req_valid && req_write && req_word && (region == REG_TRIG);
    assign set_wr  = req_valid && req_write && (region == REG_SET);
    assign clr_wr  = req_valid && req_write && (region == REG_CLR);
    assign rd_fire = req_valid && !req_write;
    assign rd_win  = (region == REG_SET) || (region == REG_CLR);

    assign lane_byte = req_wdata[{req_addr[1:0], 3'b000} +: 8];

    for (genvar s = 0; s < NSGI; s++) begin : g_lane
        localparam logic [SW-1:0] SI = SW'(s);
        assign sel[s] = req_word ? (SI[SW-1:2] == req_addr[SW-1:2])
                                 : (SI == req_addr[SW-1:0]);
        assign bytes[s*8 +: 8] = req_word ? req_wdata[(s%4)*8 +: 8] : lane_byte;
    end

endmodule

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
    import sgi_pkg::*;
#(
    parameter int NCPU = 8
) (
    input  logic [1:0]                  mode,
    input  logic [7:0]                  list,
    input  logic [$clog2(NCPU)-1:0]     src,
    input  logic [$clog2(NCPU+1)-1:0]   online_cpus,
    output logic [NCPU-1:0]             targets,
    output logic                        legal
);
    localparam int NW = $clog2(NCPU + 1);

    logic [NCPU-1:0] online_mask;
    logic [NCPU-1:0] self_mask;
    filt_e           filt;

    for (genvar i = 0; i < NCPU; i++) begin : g_online
        assign online_mask[i] = NW'(i) < online_cpus;
    end

    assign self_mask = NCPU'(1) << src;
    assign filt      = filt_e'(mode);

    always_comb begin
        targets = '0;
        legal   = 1'b1;
        unique case (filt)
            FILT_LIST:   targets = list[NCPU-1:0] & online_mask;
            FILT_OTHERS: targets = online_mask & ~self_mask;
            FILT_SELF:   targets = self_mask;
            FILT_RSVD:   legal   = 1'b0;
        endcase
    end

endmodule

// File: rtl/sgi_source_bank.sv
module sgi_source_bank #(
    parameter int NCPU = 8,
    parameter int NSGI = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        trig_fire,
    input  logic [$clog2(NSGI)-1:0]     trig_id,
    input  logic [NCPU-1:0]             trig_tgt,
    input  logic [$clog2(NCPU)-1:0]     acc_cpu,
    input  logic                        win_set,
    input  logic                        win_clr,
    input  logic [NSGI-1:0]             win_sel,
    input  logic [NSGI*8-1:0]           win_bytes,
    input  logic                        rd_fire,
    input  logic                        rd_win,
    input  logic                        rd_word,
    input  logic [$clog2(NSGI)-1:0]     rd_idx,
    output logic [NCPU*NSGI-1:0]        pend,
    output logic [31:0]                 rd_data
);
    localparam int SW = $clog2(NSGI);

    typedef struct packed {
        logic [NCPU-1:0][NSGI-1:0][NCPU-1:0] mask;
        logic [31:0]                         rd;
    } bank_t;

    bank_t st_d, st_q;
    logic [SW-1:0] idx;

    always_comb begin
        st_d = st_q;
        idx  = '0;

        // Trigger: mark the writer as a sender at every recipient.
        if (trig_fire) begin
            for (int c = 0; c < NCPU; c++) begin
                if (trig_tgt[c])
                    st_d.mask[c][trig_id][acc_cpu] = 1'b1;
            end
        end

        // Window writes act on the accessing CPU's own bank.
        for (int s = 0; s < NSGI; s++) begin
            if (win_sel[s] && win_set)
                st_d.mask[acc_cpu][s] = st_q.mask[acc_cpu][s] | win_bytes[s*8 +: NCPU];
            if (win_sel[s] && win_clr)
                st_d.mask[acc_cpu][s] = st_q.mask[acc_cpu][s] & ~win_bytes[s*8 +: NCPU];
        end

        // Read data: sender masks laid out per byte lane.
        if (rd_fire) begin
            st_d.rd = '0;
            if (rd_win) begin
                for (int l = 0; l < 4; l++) begin
                    idx = rd_word ? {rd_idx[SW-1:2], 2'(l)} : rd_idx;
                    if (rd_word || (2'(l) == rd_idx[1:0]))
                        st_d.rd[l*8 +: 8] = 8'(st_q.mask[acc_cpu][idx]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        for (genvar s = 0; s < NSGI; s++) begin : g_sgi
            assign pend[c*NSGI + s] = |st_q.mask[c][s];
        end
    end

    assign rd_data = st_q.rd;

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
    parameter int NCPU = 8,
    parameter int NSGI = 16,
    parameter int AW   = 6,
    localparam int CW  = $clog2(NCPU),
    localparam int NW  = $clog2(NCPU + 1),
    localparam int SW  = $clog2(NSGI)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic                     req_word,
    input  logic [AW-1:0]            req_addr,
    input  logic [31:0]              req_wdata,
    input  logic [CW-1:0]            req_cpu,
    input  logic [NW-1:0]            online_cpus,
    output logic [31:0]              rd_data,
    output logic [NCPU*NSGI-1:0]     sgi_pend
);
    logic                  trig_wr, set_wr, clr_wr, rd_fire, rd_win;
    logic [NSGI-1:0]       sel;
    logic [NSGI*8-1:0]     bytes;
    logic [NCPU-1:0]       targets;
    logic                  legal;

    sgi_addr_decode #(.NSGI(NSGI), .AW(AW)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_word  (req_word),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .trig_wr   (trig_wr),
        .set_wr    (set_wr),
        .clr_wr    (clr_wr),
        .rd_fire   (rd_fire),
        .rd_win    (rd_win),
        .sel       (sel),
        .bytes     (bytes)
    );

    sgi_target_decode #(.NCPU(NCPU)) u_tgt (
        .mode        (req_wdata[25:24]),
        .list        (req_wdata[23:16]),
        .src         (req_cpu),
        .online_cpus (online_cpus),
        .targets     (targets),
        .legal       (legal)
    );

    sgi_source_bank #(.NCPU(NCPU), .NSGI(NSGI)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .trig_fire (trig_wr && legal),
        .trig_id   (req_wdata[SW-1:0]),
        .trig_tgt  (targets),
        .acc_cpu   (req_cpu),
        .win_set   (set_wr),
        .win_clr   (clr_wr),
        .win_sel   (sel),
        .win_bytes (bytes),
        .rd_fire   (rd_fire),
        .rd_win    (rd_win),
        .rd_word   (req_word),
        .rd_idx    (req_addr[SW-1:0]),
        .pend      (sgi_pend),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
    parameter int NCPU = 8,
    parameter int NSGI = 16,
    parameter int AW   = 6,
    localparam int CW  = $clog2(NCPU),
    localparam int NW  = $clog2(NCPU + 1)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_write,
    input logic                  req_word,
    input logic [AW-1:0]         req_addr,
    input logic [31:0]           req_wdata,
    input logic [CW-1:0]         req_cpu,
    input logic [NW-1:0]         online_cpus,
    input logic [31:0]           rd_data,
    input logic [NCPU*NSGI-1:0]  sgi_pend
);
    logic trig_w, set_w, clr_w, trig_rd;
    logic unused_chk;

    assign trig_w  = req_valid && req_write && req_word && (req_addr == '0);
    assign trig_rd = req_valid && !req_write && (req_addr == '0);
    assign set_w   = req_valid && req_write && (req_addr[AW-1:4] == 2'd2);
    assign clr_w   = req_valid && req_write && (req_addr[AW-1:4] == 2'd1);
    assign unused_chk = ^{req_wdata[31:26], req_wdata[15:4]};

    p_rsvd_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        trig_w && req_wdata[25:24] == 2'd3 |=> $stable(sgi_pend));

    p_trig_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
        trig_rd |=> rd_data == 32'd0);

    p_clear_no_rise_r8: assert property (@(posedge clk) disable iff (rst)
        clr_w |=> (sgi_pend & ~$past(sgi_pend)) == '0);

    p_set_no_fall_r7: assert property (@(posedge clk) disable iff (rst)
        set_w |=> ($past(sgi_pend) & ~sgi_pend) == '0);

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        p_offline_drop_r6: assert property (@(posedge clk) disable iff (rst)
            trig_w && !req_wdata[25] && (NW'(c) >= online_cpus)
            |=> $stable(sgi_pend[c*NSGI +: NSGI]));

        p_self_only_r4: assert property (@(posedge clk) disable iff (rst)
            trig_w && req_wdata[25:24] == 2'd2 && (req_cpu != CW'(c))
            |=> $stable(sgi_pend[c*NSGI +: NSGI]));

        p_list_hit_r2: assert property (@(posedge clk) disable iff (rst)
            trig_w && req_wdata[25:24] == 2'd0 && req_wdata[16+c]
            && (NW'(c) < online_cpus)
            |=> sgi_pend[c*NSGI + int'($past(req_wdata[3:0]))]);
    end

endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCPU(NCPU), .NSGI(NSGI), .AW(AW)) u_chk (.*);

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [5:0]   req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [2:0]   req_cpu = '0;
    logic [3:0]   online_cpus = 4'd8;
    logic [31:0]  rd_data;
    logic [127:0] sgi_pend;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] mdl [0:7][0:15];

    always #2 clk = ~clk;

    sgi_dispatch u_dut (.*);

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] exp_pend();
        logic [127:0] v = '0;
        for (int c = 0; c < 8; c++)
            for (int s = 0; s < 16; s++)
                v[c*16+s] = |mdl[c][s];
        return v;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [2:0] cpu, input logic [5:0] a, input logic w);
        logic [31:0] r = '0;
        if (a[5:4] == 2'd1 || a[5:4] == 2'd2) begin
            if (w) for (int l = 0; l < 4; l++) r[l*8 +: 8] = mdl[cpu][{a[3:2], 2'(l)}];
            else   r[{a[1:0], 3'b000} +: 8] = mdl[cpu][a[3:0]];
        end
        return r;
    endfunction

    task automatic op(input logic wr, input logic w, input logic [5:0] a,
                      input logic [31:0] d, input logic [2:0] cpu);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = w;
        req_addr = a; req_wdata = d; req_cpu = cpu;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        // model update for writes
        if (wr && w && a == 6'd0) begin
            logic [7:0] t = '0;
            logic [7:0] on = 8'((9'd1 << online_cpus) - 9'd1);
            case (d[25:24])
                2'd0: t = d[23:16] & on;
                2'd1: t = on & ~(8'd1 << cpu);
                2'd2: t = 8'd1 << cpu;
                default: t = '0;
            endcase
            for (int c = 0; c < 8; c++)
                if (t[c]) mdl[c][d[3:0]][cpu] = 1'b1;
        end else if (wr && (a[5:4] == 2'd1 || a[5:4] == 2'd2)) begin
            for (int s = 0; s < 16; s++) begin
                logic hit = w ? (4'(s) >> 2) == {2'b00, a[3:2]} : 4'(s) == a[3:0];
                logic [7:0] b = w ? d[(s%4)*8 +: 8] : d[{a[1:0], 3'b000} +: 8];
                if (hit) mdl[cpu][s] = (a[5:4] == 2'd2) ? (mdl[cpu][s] | b) : (mdl[cpu][s] & ~b);
            end
        end
    endtask

    task automatic rd_chk(input string req, input logic w, input logic [5:0] a, input logic [2:0] cpu);
        op(1'b0, w, a, 32'hDEAD_BEEF, cpu);
        chk(req, 128'(rd_data), 128'(exp_rd(cpu, a, w)));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 8; c++) for (int s = 0; s < 16; s++) mdl[c][s] = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 pend", sgi_pend, '0);
        chk("R1 rd", 128'(rd_data), '0);

        // R2..R6: sweep modes, sources and online counts; R9 readback
        for (int on = 3; on <= 8; on += 5) begin
            online_cpus = 4'(on);
            for (int m = 0; m < 4; m++) begin
                for (int src = 0; src < 8; src++) begin
                    logic [3:0] id = 4'((src * 5 + m * 3 + on) % 16);
                    logic [7:0] lst = 8'hA5 ^ 8'(src << 2) ^ 8'(m * 17);
                    op(1'b1, 1'b1, 6'd0, {6'd0, 2'(m), lst, 12'd0, id}, 3'(src));
                    chk(m == 0 ? "R2 list" : m == 1 ? "R3 others/R6" : m == 2 ? "R4 self" : "R5 rsvd",
                        sgi_pend, exp_pend());
                    rd_chk("R9 word read", 1'b1, {2'd2, id[3:2], 2'd0}, 3'(src));
                end
            end
        end

        // R10: trigger and unmapped reads return zero
        rd_chk("R10 trig read", 1'b1, 6'd0, 3'd1);
        rd_chk("R10 unmapped read", 1'b1, 6'h30, 3'd1);

        // R1 again, then window tests from a clean state
        do_reset();
        chk("R1 pend after rerun reset", sgi_pend, '0);
        online_cpus = 4'd8;

        // R7: word set from CPU 3 into SGIs 4..7, lane 2 zero
        op(1'b1, 1'b1, 6'h24, 32'h81_00_40_05, 3'd3);
        chk("R7 set word", sgi_pend, exp_pend());
        rd_chk("R9 clr window read", 1'b1, 6'h14, 3'd3);
        // R7: zero byte write changes nothing
        op(1'b1, 1'b0, 6'h26, 32'h0, 3'd3);
        chk("R7 zero byte", sgi_pend, exp_pend());
        // R9: byte reads, other lanes zero
        for (int b = 4; b < 8; b++) rd_chk("R9 byte read", 1'b0, 6'(32 + b), 3'd3);
        // R11: other bank untouched
        rd_chk("R11 other bank", 1'b1, 6'h24, 3'd5);
        op(1'b1, 1'b0, 6'h2B, 32'h0300_0000, 3'd5);
        chk("R11 bank 5 set", sgi_pend, exp_pend());
        rd_chk("R11 bank 3 intact", 1'b1, 6'h28, 3'd3);

        // R8: partial then full clear of SGI 7 on CPU 3 (mask 0x81)
        op(1'b1, 1'b0, 6'h17, 32'h0100_0000, 3'd3);
        chk("R8 partial clear", sgi_pend, exp_pend());
        chk("R8 still pending", 128'(sgi_pend[3*16+7]), 128'(1));
        op(1'b1, 1'b0, 6'h17, 32'h8000_0000, 3'd3);
        chk("R8 cleared", 128'(sgi_pend[3*16+7]), 128'(0));
        op(1'b1, 1'b1, 6'h14, 32'hFFFF_FFFF, 3'd3);
        chk("R8 word clear", sgi_pend, exp_pend());

        // R12: read data holds after the read
        rd_chk("R12 read", 1'b1, 6'h28, 3'd5);
        @(negedge clk);
        chk("R12 hold", 128'(rd_data), 128'(exp_rd(3'd5, 6'h28, 1'b1)));

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule